// File: doc/BRIEF.md
# CAN Controller Configuration Guard

This block is the register front end that sits between a CPU register bus and a CAN protocol engine. It holds the engine's configuration: a control byte, two bit-timing bytes, an acceptance-control byte, and a bank of acceptance identifier and mask bytes. It also holds a mode byte that carries the initialization request, the power-down request, the module enable and a sticky write-rejected flag. The engine's receive and transmit error counts are visible through two read-only bytes.

The block guards the configuration against changes while the controller is on the bus. Software sets the initialization request and waits for the acknowledge. Only while the acknowledge is high do writes to the configuration bytes land. A write to a configuration byte at any other time is dropped and raises the rejected flag. The module enable takes only the first write to the mode byte after reset. Whenever the controller is initializing, acknowledged, or powered down, the transmit pin is held recessive, whatever the engine drives.

Top module: `can_cfg_guard`

## Requirements
- R1: After reset the mode byte (address 0x00) reads 0x01, the status byte (0x01) reads 0x01, and every configuration byte reads 0x00. The exception is the mask bytes at 0x10..0x17, which read 0xFF. `mod_enable` is 0 and `can_tx` is 1.
- R2: The bytes at 0x06 and 0x07 return `rx_err_cnt` and `tx_err_cnt`. Bus writes to those addresses change nothing.
- R3: While `init_ack` is 1, a write to a configuration byte lands. The configuration bytes are control 0x02, timing 0x03/0x04, acceptance control 0x05, identifiers 0x08..0x0F and masks 0x10..0x17.
- R4: While `init_ack` is 0, a write to a configuration byte is dropped, and the byte keeps its value.
- R5: A dropped configuration write sets the rejected flag, which is mode bit 6. Writing 1 to mode bit 6 clears it.
- R6: `init_ack` (status bit 0) follows the init request (mode bit 0) with a lag of exactly two clock edges. This holds both when the request is set and when it is cleared.
- R7: `can_tx` is 1 whenever the init request, `init_ack` or the power-down request (mode bit 1) is set. Otherwise it equals `eng_tx`.
- R8: Mode bit 7 (`mod_enable`) takes its value from the first write to the mode byte after reset. Later writes leave it unchanged.
- R9: `clk_sel` equals bit 0 of the control byte. It picks oscillator clock (0) or bus clock (1) for the core.
- R10: Reads are allowed at every lock state. `bus_rdata` carries the addressed byte from the clock edge where `bus_rd` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW (5) | Register address |
| bus_wdata | input | DW (8) | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DW (8) | Registered read data |
| eng_tx | input | 1 | Transmit bit from the protocol engine |
| rx_err_cnt | input | DW (8) | Receive error count from the engine |
| tx_err_cnt | input | DW (8) | Transmit error count from the engine |
| can_tx | output | 1 | Transmit pin |
| init_ack | output | 1 | Initialization acknowledged (lock open) |
| mod_enable | output | 1 | Module enable |
| clk_sel | output | 1 | Core clock source select |
| cfg_ctrl | output | DW (8) | Control byte |
| cfg_tim0 | output | DW (8) | Timing byte 0 |
| cfg_tim1 | output | DW (8) | Timing byte 1 |
| cfg_acc | output | DW (8) | Acceptance control byte |
| cfg_ids | output | NF*DW (64) | Identifier bytes, byte i at bits i*DW |
| cfg_masks | output | NF*DW (64) | Mask bytes, byte i at bits i*DW |

## Verification
The hardest state to reach is the two-edge window after the init request clears. In that window the request is already low but the acknowledge is still high, so the lock is still open and the pin must still be held. The stimulus clears the request with a single write and then samples `init_ack` and `can_tx` on each of the next falling edges. It does the same when the request is set again, then proves the lock reopened with a write and read-back of a mask byte. Locked-state drops are shown by reading the untouched byte and the rejected flag back over the bus before any further configuration write.

// File: rtl/can_cfg_pkg.sv
package can_cfg_pkg;
  // Register addresses
  localparam int unsigned A_MODE      = 0;
  localparam int unsigned A_STAT      = 1;
  localparam int unsigned A_CTRL      = 2;
  localparam int unsigned A_TIM0      = 3;
  localparam int unsigned A_TIM1      = 4;
  localparam int unsigned A_ACC       = 5;
  localparam int unsigned A_RXE       = 6;
  localparam int unsigned A_TXE       = 7;
  localparam int unsigned A_FILT_BASE = 8;
  // Number of guarded bytes below the filter bank
  localparam int unsigned N_CORE      = 4;
  // Bit positions
  localparam int unsigned B_REQ    = 0;
  localparam int unsigned B_SLEEP  = 1;
  localparam int unsigned B_REJ    = 6;
  localparam int unsigned B_EN     = 7;
  localparam int unsigned B_CLKSEL = 0;

  typedef enum logic [2:0] {RC_MODE, RC_STAT, RC_PROT, RC_ERRC, RC_NONE} reg_class_e;

  function automatic reg_class_e classify(input int unsigned a, input int unsigned nf);
    if (a == A_MODE) return RC_MODE;
    if (a == A_STAT) return RC_STAT;
    if (a >= A_CTRL && a <= A_ACC) return RC_PROT;
    if (a == A_RXE || a == A_TXE) return RC_ERRC;
    if (a >= A_FILT_BASE && a < A_FILT_BASE + 2 * nf) return RC_PROT;
    return RC_NONE;
  endfunction

  // Storage slot of a guarded byte
  function automatic int unsigned prot_slot(input int unsigned a);
    if (a <= A_ACC) return a - A_CTRL;
    return a - A_FILT_BASE + N_CORE;
  endfunction
endpackage

// File: rtl/can_init_sync.sv
module can_init_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic ack
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= req;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[STAGES-2:0], req};
      end
    end
  endgenerate

  assign ack = pipe[STAGES-1];
endmodule

// File: rtl/can_cfg_regs.sv
module can_cfg_regs
  import can_cfg_pkg::*;
#(
  parameter int DW = 8,
  parameter int NF = 8,
  parameter int AW = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             unlocked,
  output logic [DW-1:0]    rdata_c,
  output logic             reject,
  output logic [DW-1:0]    ctrl,
  output logic [DW-1:0]    tim0,
  output logic [DW-1:0]    tim1,
  output logic [DW-1:0]    acc,
  output logic [NF*DW-1:0] ids,
  output logic [NF*DW-1:0] masks
);
  localparam int NTOT = N_CORE + 2 * NF;
  localparam int IW   = $clog2(NTOT);

  logic [DW-1:0] store [NTOT];
  logic          is_prot;
  logic [IW-1:0] slot;

  always_comb begin
    is_prot = (classify(32'(addr), NF) == RC_PROT);
    slot    = is_prot ? IW'(prot_slot(32'(addr))) : '0;
  end

  assign reject = wr && is_prot && !unlocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTOT; i++)
        store[i] <= (i >= N_CORE + NF) ? {DW{1'b1}} : '0;
    end else if (wr && is_prot && unlocked) begin
      store[slot] <= wdata;
    end
  end

  assign rdata_c = is_prot ? store[slot] : '0;
  assign ctrl    = store[0];
  assign tim0    = store[1];
  assign tim1    = store[2];
  assign acc     = store[3];

  generate
    for (genvar i = 0; i < NF; i++) begin : g_filt
      assign ids[i*DW +: DW]   = store[N_CORE + i];
      assign masks[i*DW +: DW] = store[N_CORE + NF + i];
    end
  endgenerate
endmodule

// File: rtl/can_tx_guard.sv
module can_tx_guard (
  input  logic eng_tx,
  input  logic hold,
  output logic can_tx
);
  // Recessive level is logic 1
  assign can_tx = hold | eng_tx;
endmodule

// File: rtl/can_cfg_guard.sv
module can_cfg_guard
  import can_cfg_pkg::*;
#(
  parameter int DW          = 8,
  parameter int NF          = 8,
  parameter int AW          = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             bus_wr,
  input  logic             bus_rd,
  output logic [DW-1:0]    bus_rdata,
  input  logic             eng_tx,
  input  logic [DW-1:0]    rx_err_cnt,
  input  logic [DW-1:0]    tx_err_cnt,
  output logic             can_tx,
  output logic             init_ack,
  output logic             mod_enable,
  output logic             clk_sel,
  output logic [DW-1:0]    cfg_ctrl,
  output logic [DW-1:0]    cfg_tim0,
  output logic [DW-1:0]    cfg_tim1,
  output logic [DW-1:0]    cfg_acc,
  output logic [NF*DW-1:0] cfg_ids,
  output logic [NF*DW-1:0] cfg_masks
);
  localparam logic [AW-1:0] AD_MODE = AW'(A_MODE);
  localparam logic [AW-1:0] AD_RXE  = AW'(A_RXE);

  logic       init_req, sleep_req, en_spent, rej_flag;
  logic       reject_set, mode_wr;
  logic [DW-1:0] prot_rdata, rd_mux;
  reg_class_e rd_class;

  assign mode_wr = bus_wr && (bus_addr == AD_MODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      init_req   <= 1'b1;
      sleep_req  <= 1'b0;
      mod_enable <= 1'b0;
      en_spent   <= 1'b0;
    end else if (mode_wr) begin
      init_req  <= bus_wdata[B_REQ];
      sleep_req <= bus_wdata[B_SLEEP];
      if (!en_spent) begin
        mod_enable <= bus_wdata[B_EN];
        en_spent   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                               rej_flag <= 1'b0;
    else if (reject_set)                   rej_flag <= 1'b1;
    else if (mode_wr && bus_wdata[B_REJ])  rej_flag <= 1'b0;
  end

  can_init_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .req (init_req),
    .ack (init_ack)
  );

  can_cfg_regs #(.DW(DW), .NF(NF), .AW(AW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .unlocked (init_ack),
    .rdata_c  (prot_rdata),
    .reject   (reject_set),
    .ctrl     (cfg_ctrl),
    .tim0     (cfg_tim0),
    .tim1     (cfg_tim1),
    .acc      (cfg_acc),
    .ids      (cfg_ids),
    .masks    (cfg_masks)
  );

  can_tx_guard u_tx (
    .eng_tx (eng_tx),
    .hold   (init_req | init_ack | sleep_req),
    .can_tx (can_tx)
  );

  assign clk_sel = cfg_ctrl[B_CLKSEL];

  always_comb begin
    rd_class = classify(32'(bus_addr), NF);
    rd_mux   = '0;
    case (rd_class)
      RC_MODE: begin
        rd_mux[B_REQ]   = init_req;
        rd_mux[B_SLEEP] = sleep_req;
        rd_mux[B_REJ]   = rej_flag;
        rd_mux[B_EN]    = mod_enable;
      end
      RC_STAT: begin
        rd_mux[0] = init_ack;
        rd_mux[1] = sleep_req;
      end
      RC_PROT: rd_mux = prot_rdata;
      RC_ERRC: rd_mux = (bus_addr == AD_RXE) ? rx_err_cnt : tx_err_cnt;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/can_cfg_guard_chk.sv
module can_cfg_guard_chk
  import can_cfg_pkg::*;
#(
  parameter int DW = 8,
  parameter int NF = 8,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [DW-1:0] bus_rdata,
  input logic [DW-1:0] rx_err_cnt,
  input logic          can_tx,
  input logic          init_req,
  input logic          init_ack,
  input logic          en_spent,
  input logic          mod_enable,
  input logic          rej_flag,
  input logic [DW-1:0] cfg_tim0,
  input logic [DW-1:0] cfg_tim1
);
  localparam logic [AW-1:0] AD_MODE = AW'(A_MODE);
  localparam logic [AW-1:0] AD_TIM0 = AW'(A_TIM0);
  localparam logic [AW-1:0] AD_TIM1 = AW'(A_TIM1);
  localparam logic [AW-1:0] AD_RXE  = AW'(A_RXE);

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)           age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  logic prot_wr;
  assign prot_wr = bus_wr && (classify(32'(bus_addr), NF) == RC_PROT);

  assert_ack_lag_R6: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2) |-> (init_ack == $past(init_req, 2)));

  assert_tx_recessive_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AD_MODE && (bus_wdata[B_REQ] || bus_wdata[B_SLEEP])) |=> can_tx);

  assert_locked_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AD_TIM0 && !init_ack) |=> $stable(cfg_tim0));

  assert_reject_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (prot_wr && !init_ack) |=> rej_flag);

  assert_open_write_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AD_TIM1 && init_ack) |=> (cfg_tim1 == $past(bus_wdata)));

  assert_enable_once_R8: assert property (@(posedge clk) disable iff (rst)
    en_spent |=> $stable(mod_enable));

  assert_errcnt_read_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == AD_RXE) |=> (bus_rdata == $past(rx_err_cnt)));
endmodule

bind can_cfg_guard can_cfg_guard_chk #(.DW(DW), .NF(NF), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_rdata  (bus_rdata),
  .rx_err_cnt (rx_err_cnt),
  .can_tx     (can_tx),
  .init_req   (init_req),
  .init_ack   (init_ack),
  .en_spent   (en_spent),
  .mod_enable (mod_enable),
  .rej_flag   (rej_flag),
  .cfg_tim0   (cfg_tim0),
  .cfg_tim1   (cfg_tim1)
);

// File: tb/tb_can_cfg_guard.sv
module tb_can_cfg_guard;
  localparam int DW = 8;
  localparam int NF = 8;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic eng_tx = 1'b0;
  logic [DW-1:0] rx_err_cnt = '0, tx_err_cnt = '0;
  logic can_tx, init_ack, mod_enable, clk_sel;
  logic [DW-1:0] cfg_ctrl, cfg_tim0, cfg_tim1, cfg_acc;
  logic [NF*DW-1:0] cfg_ids, cfg_masks;

  always #4 clk = ~clk;

  can_cfg_guard #(.DW(DW), .NF(NF), .AW(AW)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .eng_tx(eng_tx),
    .rx_err_cnt(rx_err_cnt), .tx_err_cnt(tx_err_cnt), .can_tx(can_tx),
    .init_ack(init_ack), .mod_enable(mod_enable), .clk_sel(clk_sel),
    .cfg_ctrl(cfg_ctrl), .cfg_tim0(cfg_tim0), .cfg_tim1(cfg_tim1),
    .cfg_acc(cfg_acc), .cfg_ids(cfg_ids), .cfg_masks(cfg_masks)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic          rd_q = 1'b0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver tasks
  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_addr = AW'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // Monitor
  always @(posedge clk) rd_q <= bus_rd;
  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() == 0) chk("R10 unexpected read", bus_rdata, 'x);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog all-requirements actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    chk("R1 can_tx", DW'(can_tx), 8'h01);
    chk("R1 mod_enable", DW'(mod_enable), 8'h00);
    chk("R9 clk_sel reset", DW'(clk_sel), 8'h00);
    rd(0, 8'h01, "R1 mode");
    rd(1, 8'h01, "R1 stat");
    rd(3, 8'h00, "R1 tim0");
    rd(8, 8'h00, "R1 id0");
    rd(16, 8'hFF, "R1 mask0");
    rd(23, 8'hFF, "R1 mask7");
    // R3 writes while acknowledged
    wr(3, 8'h5A); wr(11, 8'h33); wr(23, 8'h0F); wr(2, 8'h01);
    rd(3, 8'h5A, "R3 tim0");
    rd(11, 8'h33, "R3 id3");
    rd(23, 8'h0F, "R3 mask7");
    chk("R9 clk_sel", DW'(clk_sel), 8'h01);
    // R2 error counters
    rx_err_cnt = 8'h12; tx_err_cnt = 8'h34;
    wr(6, 8'hFF); wr(7, 8'hEE);
    rd(6, 8'h12, "R2 rx");
    rd(7, 8'h34, "R2 tx");
    // R8 enable write-once
    wr(0, 8'h81);
    chk("R8 enable set", DW'(mod_enable), 8'h01);
    wr(0, 8'h01);
    chk("R8 enable kept", DW'(mod_enable), 8'h01);
    rd(0, 8'h81, "R8 mode");
    // R6 acknowledge fall, R7 hold during lag
    wr(0, 8'h80);
    chk("R6 ack lag0", DW'(init_ack), 8'h01);
    chk("R7 held in lag", DW'(can_tx), 8'h01);
    @(negedge clk);
    chk("R6 ack lag1", DW'(init_ack), 8'h01);
    @(negedge clk);
    chk("R6 ack fell", DW'(init_ack), 8'h00);
    chk("R7 follows engine 0", DW'(can_tx), 8'h00);
    eng_tx = 1'b1; #1;
    chk("R7 follows engine 1", DW'(can_tx), 8'h01);
    eng_tx = 1'b0;
    // R4/R5 locked write
    wr(3, 8'hA5); wr(20, 8'h77);
    rd(3, 8'h5A, "R4 tim0 kept");
    rd(20, 8'hFF, "R4 mask4 kept");
    rd(0, 8'hC0, "R5 flag set");
    rd(1, 8'h00, "R10 stat locked");
    wr(0, 8'h40);
    rd(0, 8'h80, "R5 flag cleared");
    // R7 power-down
    wr(0, 8'h02);
    chk("R7 power-down", DW'(can_tx), 8'h01);
    chk("R7 ack still low", DW'(init_ack), 8'h00);
    wr(0, 8'h00);
    chk("R7 released", DW'(can_tx), 8'h00);
    // R6 acknowledge rise, lock reopens
    wr(0, 8'h01);
    chk("R7 request holds", DW'(can_tx), 8'h01);
    chk("R6 rise lag0", DW'(init_ack), 8'h00);
    @(negedge clk);
    chk("R6 rise lag1", DW'(init_ack), 8'h00);
    @(negedge clk);
    chk("R6 ack rose", DW'(init_ack), 8'h01);
    wr(16, 8'h3C);
    rd(16, 8'h3C, "R3 mask0 reopened");
    rd(11, 8'h33, "R10 id3 kept");
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule